// File: doc/BRIEF.md
# Serial Control Word Receiver for a PLL Synthesizer

This block takes the three-wire programming bus of a frequency synthesizer (a serial data line, a bus clock and a frame enable) and turns each complete 26-bit control word into the parallel settings of the loop. Those settings are the 17-bit feedback divider ratio, the 4-bit reference divider select, the 2-bit charge-pump current code, the two switching-port sink controls and the test-mode controls. All three bus lines are slow, asynchronous pins. They are resynchronised into the system clock and sampled there. A bit is taken on each rising bus clock edge while the frame enable is high. The word is committed when the enable falls.

Only a frame of exactly 26 bits is accepted. The non-ratio fields take effect as soon as the frame is committed. The divider ratio is held in a pending register and is applied only when the divider reports the end of its cycle on `div_sync`, so that retuning does not disturb a running count. Bit T0 decides what the port bits mean. When it is clear, the port bits drive the two switching ports. When it is set, the port bits choose a charge-pump override or an observation routing.

The settings are plain control levels, so the block has no valid/ready handshake. Every output is a registered level that holds until the next accepted frame or the next ratio transfer, so no back-pressure can arise.

Top module: `synth_prog_if`

## Requirements
- R1: The frame is sent most significant bit first, and bit positions count from the last bit sent (bit 0). Bit 25 is P1, bit 24 is P0, bit 23 is T0, bits 22:21 are the current code C1C0, bits 20:18 are R2..R0, bit 17 is RD and bits 16:0 are the divider ratio. `ref_sel` presents {RD,R2,R1,R0}.
- R2: A bit is sampled from `bus_data` on each rising edge of `bus_clk` only while `bus_en` is high. Rising edges of `bus_clk` while `bus_en` is low are not counted and do not add bits to the frame.
- R3: On a falling edge of `bus_en`, a frame of exactly 26 sampled bits is committed. A frame of any other length leaves every output unchanged.
- R4: `cp_code` presents C1C0 from the last committed frame. The codes mean: 00 for ±230 µA, 01 for ±1000 µA, 10 for ±115 µA and 11 for ±500 µA.
- R5: A committed ratio is held pending and appears on `ratio` in the cycle after a `div_sync` pulse. `ratio` never changes in a cycle that does not follow a `div_sync` pulse.
- R6: With T0 = 0, `port_on` = {P1,P0}, where 1 means the port sinks current and 0 means it is high-impedance. All test controls are 0 in this mode.
- R7: With T0 = 1, `port_on` is 00 and P1P0 selects exactly one test control. 00 asserts `cp_force_sink`, 01 asserts `cp_force_source`, 10 asserts `cp_disable`, and 11 asserts `obs_route` (comparison clock to P1, divider output /2 to P0).
- R8: After reset, and until the first frame is committed, all outputs are 0. This means both ports are high-impedance and no test mode is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | 1 | Serial data pin (asynchronous) |
| bus_clk | input | 1 | Serial bus clock pin (asynchronous) |
| bus_en | input | 1 | Frame enable pin (asynchronous) |
| div_sync | input | 1 | One-cycle end-of-divider-cycle strobe |
| ratio | output | 17 | Active feedback divider ratio |
| ref_sel | output | 4 | Reference divider select {RD,R2,R1,R0} |
| cp_code | output | 2 | Charge-pump current code C1C0 |
| port_on | output | 2 | Port sink enables {P1,P0}; 0 = high-impedance |
| cp_force_sink | output | 1 | Test: charge pump forced to sink |
| cp_force_source | output | 1 | Test: charge pump forced to source |
| cp_disable | output | 1 | Test: charge pump disabled |
| obs_route | output | 1 | Test: comparison and divider/2 clocks routed to the ports |

## Verification
The bench builds the block with its defaults: a 17-bit ratio and a two-stage synchronizer. These values put every field at its real bit position, so a misplaced field slice shows up directly. The sweep covers all eight combinations of P1, P0 and T0 crossed with all four current codes, and it walks the reference select and the ratio through arithmetic sequences. For each frame it checks that the ratio stays pending until `div_sync`. Frames of 25 and 27 bits, and stray bus clocks sent while the enable is low, exercise the rule that only an exact-length frame is accepted.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  // Number of control bits above the ratio field
  localparam int CTRL_BITS = 9;

  // Test selections by P1P0 when T0 = 1
  typedef enum logic [1:0] {
    TM_SINK   = 2'b00,
    TM_SOURCE = 2'b01,
    TM_OFF    = 2'b10,
    TM_OBSERVE = 2'b11
  } test_sel_e;
endpackage

// File: rtl/synth_bus_sync.sv
module synth_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic data_i,
  input  logic sclk_i,
  input  logic en_i,
  output logic data_s,
  output logic en_s,
  output logic sclk_rise,
  output logic en_fall
);
  logic [2:0] stg [STAGES];
  logic       sclk_d, en_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      sclk_d <= 1'b0;
      en_d   <= 1'b0;
    end else begin
      stg[0] <= {data_i, sclk_i, en_i};
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      sclk_d <= stg[STAGES-1][1];
      en_d   <= stg[STAGES-1][0];
    end
  end

  assign data_s    = stg[STAGES-1][2];
  assign en_s      = stg[STAGES-1][0];
  assign sclk_rise = stg[STAGES-1][1] & ~sclk_d;
  assign en_fall   = en_d & ~stg[STAGES-1][0];
endmodule

// File: rtl/synth_frame_shifter.sv
module synth_frame_shifter #(
  parameter int FRAME_W = 26
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               data_s,
  input  logic               en_s,
  input  logic               sclk_rise,
  input  logic               en_fall,
  output logic               commit_q,
  output logic [FRAME_W-1:0] word_q
);
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam int CNT_SAT = FRAME_W + 1;

  logic [FRAME_W-1:0] sr;
  logic [CNT_W-1:0]   cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (!en_s) begin
      cnt <= '0;
    end else if (sclk_rise) begin
      sr <= {sr[FRAME_W-2:0], data_s};
      if (cnt != CNT_W'(CNT_SAT)) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_q <= 1'b0;
      word_q   <= '0;
    end else begin
      commit_q <= en_fall && (cnt == CNT_W'(FRAME_W));
      if (en_fall && (cnt == CNT_W'(FRAME_W))) word_q <= sr;
    end
  end
endmodule

// File: rtl/synth_ctrl_decode.sv
module synth_ctrl_decode
  import synth_prog_pkg::*;
#(
  parameter int RATIO_W = 17,
  localparam int FRAME_W = RATIO_W + CTRL_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic [FRAME_W-1:0] word,
  input  logic               div_sync,
  output logic [RATIO_W-1:0] ratio,
  output logic [3:0]         ref_sel,
  output logic [1:0]         cp_code,
  output logic [1:0]         port_on,
  output logic               cp_force_sink,
  output logic               cp_force_source,
  output logic               cp_disable,
  output logic               obs_route
);
  logic [RATIO_W-1:0] ratio_pend;
  logic               pend_vld;
  logic               t0;
  logic [1:0]         pbits;
  test_sel_e          tsel;

  assign t0    = word[RATIO_W+6];
  assign pbits = {word[RATIO_W+8], word[RATIO_W+7]};
  assign tsel  = test_sel_e'(pbits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_pend <= '0;
      pend_vld   <= 1'b0;
      ratio      <= '0;
    end else begin
      if (div_sync && pend_vld) ratio <= ratio_pend;
      if (commit) begin
        ratio_pend <= word[RATIO_W-1:0];
        pend_vld   <= 1'b1;
      end else if (div_sync) begin
        pend_vld   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_sel         <= '0;
      cp_code         <= '0;
      port_on         <= '0;
      cp_force_sink   <= 1'b0;
      cp_force_source <= 1'b0;
      cp_disable      <= 1'b0;
      obs_route       <= 1'b0;
    end else if (commit) begin
      ref_sel         <= {word[RATIO_W], word[RATIO_W+3:RATIO_W+1]};
      cp_code         <= word[RATIO_W+5:RATIO_W+4];
      port_on         <= t0 ? 2'b00 : pbits;
      cp_force_sink   <= t0 && (tsel == TM_SINK);
      cp_force_source <= t0 && (tsel == TM_SOURCE);
      cp_disable      <= t0 && (tsel == TM_OFF);
      obs_route       <= t0 && (tsel == TM_OBSERVE);
    end
  end
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
  import synth_prog_pkg::*;
#(
  parameter int RATIO_W = 17,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_data,
  input  logic               bus_clk,
  input  logic               bus_en,
  input  logic               div_sync,
  output logic [RATIO_W-1:0] ratio,
  output logic [3:0]         ref_sel,
  output logic [1:0]         cp_code,
  output logic [1:0]         port_on,
  output logic               cp_force_sink,
  output logic               cp_force_source,
  output logic               cp_disable,
  output logic               obs_route
);
  localparam int FRAME_W = RATIO_W + CTRL_BITS;

  logic               data_s, en_s, sclk_rise, en_fall;
  logic               commit_q;
  logic [FRAME_W-1:0] word_q;

  synth_bus_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .data_i(bus_data), .sclk_i(bus_clk), .en_i(bus_en),
    .data_s(data_s), .en_s(en_s), .sclk_rise(sclk_rise), .en_fall(en_fall)
  );

  synth_frame_shifter #(.FRAME_W(FRAME_W)) shift_i (
    .clk(clk), .rst_n(rst_n),
    .data_s(data_s), .en_s(en_s), .sclk_rise(sclk_rise), .en_fall(en_fall),
    .commit_q(commit_q), .word_q(word_q)
  );

  synth_ctrl_decode #(.RATIO_W(RATIO_W)) dec_i (
    .clk(clk), .rst_n(rst_n),
    .commit(commit_q), .word(word_q), .div_sync(div_sync),
    .ratio(ratio), .ref_sel(ref_sel), .cp_code(cp_code), .port_on(port_on),
    .cp_force_sink(cp_force_sink), .cp_force_source(cp_force_source),
    .cp_disable(cp_disable), .obs_route(obs_route)
  );
endmodule

// File: rtl/synth_prog_if_chk.sv
module synth_prog_if_chk #(
  parameter int RATIO_W = 17
) (
  input logic               clk,
  input logic               rst_n,
  input logic               commit,
  input logic               div_sync,
  input logic [RATIO_W-1:0] ratio,
  input logic [3:0]         ref_sel,
  input logic [1:0]         cp_code,
  input logic [1:0]         port_on,
  input logic               cp_force_sink,
  input logic               cp_force_source,
  input logic               cp_disable,
  input logic               obs_route
);
  logic [3:0] tst;
  assign tst = {cp_force_sink, cp_force_source, cp_disable, obs_route};

  AST_TEST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tst)); // R7

  AST_PORTS_OFF_IN_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    (tst != 4'b0) |-> (port_on == 2'b00)); // R7

  AST_RATIO_WAITS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !div_sync |=> $stable(ratio)); // R5

  AST_FIELDS_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable({ref_sel, cp_code, port_on, tst})); // R3
endmodule

bind synth_prog_if synth_prog_if_chk #(.RATIO_W(RATIO_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .commit(commit_q), .div_sync(div_sync),
  .ratio(ratio), .ref_sel(ref_sel), .cp_code(cp_code), .port_on(port_on),
  .cp_force_sink(cp_force_sink), .cp_force_source(cp_force_source),
  .cp_disable(cp_disable), .obs_route(obs_route)
);

// File: tb/synth_prog_if_tb.sv
module synth_prog_if_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_data = 1'b0, bus_clk = 1'b0, bus_en = 1'b0, div_sync = 1'b0;
  logic [16:0] ratio;
  logic [3:0]  ref_sel;
  logic [1:0]  cp_code, port_on;
  logic        cp_force_sink, cp_force_source, cp_disable, obs_route;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_prog_if dut_i (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_clk(bus_clk),
    .bus_en(bus_en), .div_sync(div_sync), .ratio(ratio), .ref_sel(ref_sel),
    .cp_code(cp_code), .port_on(port_on), .cp_force_sink(cp_force_sink),
    .cp_force_source(cp_force_source), .cp_disable(cp_disable),
    .obs_route(obs_route)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stray_clocks(input int n);
    for (int i = 0; i < n; i++) begin
      bus_clk = 1'b1; wait_clk(HALF_BIT);
      bus_clk = 1'b0; wait_clk(HALF_BIT);
    end
  endtask

  // Send the low nbits of w, most significant first
  task automatic send(input logic [31:0] w, input int nbits);
    bus_en = 1'b1; wait_clk(HALF_BIT);
    for (int i = nbits - 1; i >= 0; i--) begin
      bus_data = w[i]; wait_clk(HALF_BIT);
      bus_clk = 1'b1;  wait_clk(HALF_BIT);
      bus_clk = 1'b0;
    end
    wait_clk(HALF_BIT);
    bus_en = 1'b0;
    wait_clk(8);
  endtask

  task automatic pulse_sync();
    div_sync = 1'b1; wait_clk(1);
    div_sync = 1'b0; wait_clk(1);
  endtask

  // Expected decode of a committed frame (R1, R4, R6, R7)
  task automatic check_fields(input logic [25:0] w);
    logic [1:0] p;
    logic       t0;
    p  = w[25:24];
    t0 = w[23];
    chk("R1 ref_sel", 32'(ref_sel), 32'({w[17], w[20:18]}));
    chk("R4 cp_code", 32'(cp_code), 32'(w[22:21]));
    chk(t0 ? "R7 port_on" : "R6 port_on", 32'(port_on), t0 ? 32'd0 : 32'(p));
    chk(t0 ? "R7 test" : "R6 test",
        32'({cp_force_sink, cp_force_source, cp_disable, obs_route}),
        t0 ? 32'(4'b1000 >> p) : 32'd0);
  endtask

  logic [25:0] last_w;
  logic [16:0] last_ratio;

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    // R8: reset state
    chk("R8 ratio", 32'(ratio), 0);
    chk("R8 outputs", 32'({ref_sel, cp_code, port_on, cp_force_sink,
        cp_force_source, cp_disable, obs_route}), 0);

    // Sweep P1 P0 T0 x C1C0 with arithmetic ratios and ref selects
    last_ratio = '0;
    for (int k = 0; k < 32; k++) begin
      logic [16:0] r;
      logic [3:0]  rs;
      logic [2:0]  ptt;
      r   = 17'((k * 4099 + 240) % 131072);
      rs  = 4'((k * 7 + 3) % 16);
      ptt = 3'(k >> 2);
      last_w = {ptt, 2'(k), rs[2:0], rs[3], r};
      send(32'(last_w), 26);
      check_fields(last_w);
      chk("R5 ratio pending", 32'(ratio), 32'(last_ratio));
      pulse_sync();
      chk("R5 ratio applied", 32'(ratio), 32'(r));
      last_ratio = r;
    end

    // R3: short and long frames are discarded
    send(32'h1ABCDEF & 32'h1FFFFFF, 25);
    pulse_sync();
    check_fields(last_w);
    chk("R3 short frame ratio", 32'(ratio), 32'(last_ratio));
    send(32'h5A5A5A5, 27);
    pulse_sync();
    check_fields(last_w);
    chk("R3 long frame ratio", 32'(ratio), 32'(last_ratio));

    // R2: clocks while enable low are not counted (23 + 3 would make 26)
    stray_clocks(3);
    send(32'h0123456 & 32'h7FFFFF, 23);
    pulse_sync();
    check_fields(last_w);
    chk("R2 stray clocks ignored", 32'(ratio), 32'(last_ratio));

    // R2/R1: a clean frame after the stray clocks is accepted, P1P0 = 11, T0 = 0
    last_w = {3'b110, 2'b01, 3'b101, 1'b1, 17'h1_0001};
    stray_clocks(2);
    send(32'(last_w), 26);
    check_fields(last_w);
    pulse_sync();
    chk("R2 frame after stray", 32'(ratio), 32'h1_0001);

    // R5: a sync with nothing pending leaves ratio unchanged
    pulse_sync();
    chk("R5 no pending", 32'(ratio), 32'h1_0001);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule